// File: doc/BRIEF.md
# Gated-Count Bang-Bang Frequency Comparator

This block checks a fast oscillator clock against a slower reference clock by counting. A divider clocked by the reference marks a measurement window of a fixed number of reference cycles (125 by default, so a 10 MHz reference gives an 80 kHz window). The divider output is registered in its own clock domain and then brought into the oscillator domain through a two-flop synchronizer. Each synchronized window boundary restarts a counter of oscillator rising edges. The total for the finished window is compared against an expected count, 1944 by default, which is the count for 155.52 MHz.

Each completed window yields a three-way decision (raise, lower or keep the oscillator frequency) and a signed, saturated count error. Both suit a bang-bang loop filter, where only the sign steers the correction. A count one above nominal means the oscillator runs fast by about 80 kHz. A count one below means it runs slow by the same amount. The window that is running when reset is released is partial, so it is discarded.

Results leave on a valid/ready stream. A result stays on the outputs, unchanged, until the consumer takes it with ready high. If the consumer stalls for a whole window, the newer result replaces the one not yet taken, because only the latest frequency estimate is of use to the loop. No stall reaches back into the counting, so windows are never lost or stretched.

Top module: `gate_freq_cmp`

## Requirements
- R1: The window boundary toggles once every DIV_RATIO (default 125) reference clock cycles, so one window spans exactly DIV_RATIO reference periods.
- R2: The reported error res_err is the number of oscillator rising edges between two successive synchronized window boundaries minus NOMINAL (default 1944), as an ERR_W-bit (default 8) two's complement value.
- R3: res_dir is 2'b01 (raise frequency) when the count is below NOMINAL, 2'b10 (lower frequency) when above, and 2'b00 (hold) when equal; its sign agrees with res_err.
- R4: res_err saturates at +127 and -127 (that is, ±(2^(ERR_W-1)-1)), and -128 never appears.
- R5: The window in progress at reset release is discarded: the first result appears only after the second synchronized window boundary, about two windows after reset.
- R6: While res_valid is high and res_ready is low, res_dir and res_err hold steady unless a newer window completes. A result taken with res_ready high clears res_valid on the next cycle if no new result arrives.
- R7: During reset res_valid is 0, res_dir is 2'b00 and res_err is 0.
- R8: With res_ready held high, one result is issued per window, and consecutive results are exactly one window length of oscillator cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Asynchronous active-low reset, reference domain |
| osc_clk | input | 1 | Oscillator clock being measured |
| osc_rst_n | input | 1 | Asynchronous active-low reset, oscillator domain |
| res_valid | output | 1 | A result is available |
| res_ready | input | 1 | Consumer takes the result |
| res_dir | output | 2 | Decision: 00 hold, 01 raise, 10 lower |
| res_err | output | ERR_W | Signed, saturated count error |

## Verification
The reference period is set so that a window holds an exact whole number of oscillator cycles. Directed counts of nominal, one above and one below separate the three decisions at their boundary. Counts of exactly ±127 and ±128 separate correct saturation from wraparound or an off-by-one clamp. Random counts up to 200 away from nominal test the subtraction over the whole range. Timing the first result after reset shows whether the partial window was discarded, and the interval between successive results shows the window length. A long stall with ready low, followed by a single accept, tests hold and release of the output stream.

// File: rtl/gfc_pkg.sv
package gfc_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DOWN = 2'b10
  } dir_e;
endpackage

// File: rtl/gfc_gate_div.sv
// Reference-domain window divider; the toggle output is a register in its own clock domain.
module gfc_gate_div #(
  parameter int DIV_RATIO = 125
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic gate_tgl
);
  localparam int DW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV_RATIO - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      cnt      <= '0;
      gate_tgl <= 1'b0;
    end else if (cnt == LAST) begin
      cnt      <= '0;
      gate_tgl <= ~gate_tgl;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: divider state never leaves its range
  p_div_range_r1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    cnt <= LAST);
  // R1: the window toggle only follows the last divider state
  p_gate_step_r1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (gate_tgl != $past(gate_tgl)) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/gfc_gate_sync.sv
// Carries the window toggle into the oscillator domain and turns each change into a one-cycle tick.
module gfc_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic osc_clk,
  input  logic osc_rst_n,
  input  logic gate_tgl,
  output logic tick
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], gate_tgl};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick = sync_q[STAGES-1] ^ last_q;

  // R8: a window boundary is a single-cycle event
  p_tick_single_r8: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    tick |=> !tick);
endmodule

// File: rtl/gfc_window_count.sv
// Counts oscillator edges between ticks; the first boundary after reset only arms the counter.
module gfc_window_count #(
  parameter int CNT_W = 14
) (
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  input  logic             tick,
  output logic             meas_stb,
  output logic [CNT_W-1:0] meas
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             armed;

  assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      cnt      <= '0;
      meas     <= '0;
      meas_stb <= 1'b0;
      armed    <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      meas     <= cnt_inc;
      meas_stb <= armed;
      armed    <= 1'b1;
    end else begin
      cnt      <= cnt_inc;
      meas_stb <= 1'b0;
    end
  end

  // R5: the boundary that arms the counter yields no measurement
  p_first_drop_r5: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    $rose(armed) |-> !meas_stb);
  // R8: a measurement is issued only right after a boundary
  p_stb_after_tick_r8: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    tick |=> (meas_stb == $past(armed)));
endmodule

// File: rtl/gfc_decide.sv
// Turns a window count into a three-way decision and a saturated signed error.
module gfc_decide
  import gfc_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int ERR_W   = 8,
  parameter int NOMINAL = 1944
) (
  input  logic [CNT_W-1:0] meas,
  output dir_e             dir,
  output logic [ERR_W-1:0] err
);
  localparam int DIFF_W = CNT_W + 2;
  localparam logic signed [DIFF_W-1:0] SAT_POS = DIFF_W'((1 << (ERR_W - 1)) - 1);
  localparam logic signed [DIFF_W-1:0] SAT_NEG = -SAT_POS;
  localparam logic signed [DIFF_W-1:0] NOM_S   = DIFF_W'(NOMINAL);

  logic signed [DIFF_W-1:0] diff;

  always_comb begin
    diff = $signed({2'b00, meas}) - NOM_S;
    if (diff > SAT_POS)      err = ERR_W'(SAT_POS);
    else if (diff < SAT_NEG) err = ERR_W'(SAT_NEG);
    else                     err = ERR_W'(diff);
    if (diff < 0)            dir = DIR_UP;
    else if (diff > 0)       dir = DIR_DOWN;
    else                     dir = DIR_HOLD;
  end
endmodule

// File: rtl/gate_freq_cmp.sv
module gate_freq_cmp
  import gfc_pkg::*;
#(
  parameter int DIV_RATIO   = 125,
  parameter int NOMINAL     = 1944,
  parameter int CNT_W       = 14,
  parameter int ERR_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             osc_clk,
  input  logic             osc_rst_n,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [1:0]       res_dir,
  output logic [ERR_W-1:0] res_err
);
  logic             gate_tgl;
  logic             tick;
  logic             meas_stb;
  logic [CNT_W-1:0] meas;
  dir_e             dec_dir;
  logic [ERR_W-1:0] dec_err;

  gfc_gate_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .gate_tgl(gate_tgl));

  gfc_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .gate_tgl(gate_tgl), .tick(tick));

  gfc_window_count #(.CNT_W(CNT_W)) u_cnt (
    .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .tick(tick),
    .meas_stb(meas_stb), .meas(meas));

  gfc_decide #(.CNT_W(CNT_W), .ERR_W(ERR_W), .NOMINAL(NOMINAL)) u_dec (
    .meas(meas), .dir(dec_dir), .err(dec_err));

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) begin
      res_valid <= 1'b0;
      res_dir   <= DIR_HOLD;
      res_err   <= '0;
    end else if (meas_stb) begin
      res_valid <= 1'b1;
      res_dir   <= dec_dir;
      res_err   <= dec_err;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R6: a stalled result stays put unless a newer window replaces it
  p_stall_hold_r6: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (res_valid && !res_ready && !meas_stb) |=> (res_valid && $stable(res_dir) && $stable(res_err)));
  // R6: an accepted result with nothing new behind it is retired
  p_accept_drop_r6: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (res_valid && res_ready && !meas_stb) |=> !res_valid);
  // R4: the most negative code is never produced
  p_no_wrap_r4: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    res_valid |-> (res_err != {1'b1, {(ERR_W-1){1'b0}}}));
  // R3: decision agrees with the sign of the error
  p_dir_sign_r3: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    res_valid |-> ((res_dir == DIR_UP) == res_err[ERR_W-1]) &&
                  ((res_dir == DIR_HOLD) == (res_err == '0)) &&
                  (res_dir != 2'b11));
endmodule

// File: tb/gate_freq_cmp_tb.sv
`timescale 1ps/1ps
module gate_freq_cmp_tb;
  localparam int NOM = 1944;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic res_ready;
  logic res_valid;
  logic [1:0] res_dir;
  logic [7:0] res_err;

  int ref_half = 80 * NOM;  // reference period = 160*N ps gives N oscillator cycles per window
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  gate_freq_cmp u_dut (
    .ref_clk(ref_clk), .ref_rst_n(rst_n), .osc_clk(osc_clk), .osc_rst_n(rst_n),
    .res_valid(res_valid), .res_ready(res_ready), .res_dir(res_dir), .res_err(res_err));

  always #10000 osc_clk = ~osc_clk;   // 50 MHz
  initial begin
    #1;  // keeps every reference edge off the oscillator edge lattice
    forever #(ref_half) ref_clk = ~ref_clk;
  end

  always @(posedge osc_clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish, cycles=%0d expected<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic int exp_err(input int n);
    int d = n - NOM;
    if (d > 127) d = 127;
    if (d < -127) d = -127;
    return d;
  endfunction

  function automatic logic [1:0] exp_dir(input int n);
    if (n < NOM) return 2'b01;
    if (n > NOM) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic get_result(output logic [1:0] d, output int e, output int at);
    @(negedge osc_clk);
    while (!res_valid) @(negedge osc_clk);
    d  = res_dir;
    e  = $signed(res_err);
    at = cyc;
    @(negedge osc_clk);
  endtask

  task automatic run_trial(input int n);
    logic [1:0] d;
    int e, at;
    ref_half = 80 * n;
    get_result(d, e, at);
    get_result(d, e, at);
    get_result(d, e, at);
    check(d == exp_dir(n), "R3 dir", int'(d), int'(exp_dir(n)));
    check(e == exp_err(n), (n - NOM > 127 || n - NOM < -127) ? "R4 sat err" : "R2 err", e, exp_err(n));
  endtask

  initial begin
    logic [1:0] d;
    int e, at, at0, rnd;
    int dirs[8];
    bit ok;
    rnd = $urandom(32'd20240611);
    res_ready = 1'b1;
    repeat (5) @(negedge osc_clk);
    // R7 reset state
    check(res_valid == 1'b0, "R7 valid", int'(res_valid), 0);
    check(res_dir == 2'b00, "R7 dir", int'(res_dir), 0);
    check(res_err == 8'd0, "R7 err", int'(res_err), 0);
    rst_n = 1'b1;
    at0 = cyc;
    // R5: first window discarded, first result about two windows after reset
    get_result(d, e, at);
    check((at - at0) > 2*NOM - 20 && (at - at0) < 2*NOM + 20, "R5 first result cycle", at - at0, 2*NOM);
    check(d == 2'b00, "R3 nominal hold", int'(d), 0);
    check(e == 0, "R2 nominal err", e, 0);
    // R8: results exactly one window apart
    at0 = at;
    get_result(d, e, at);
    check((at - at0) == NOM, "R8 interval", at - at0, NOM);
    // R6: back-pressure hold and release
    @(negedge osc_clk);
    res_ready = 1'b0;
    @(negedge osc_clk);
    while (!res_valid) @(negedge osc_clk);
    d = res_dir; e = $signed(res_err);
    ok = 1'b1;
    repeat (500) begin
      @(negedge osc_clk);
      if (!res_valid || res_dir != d || $signed(res_err) != e) ok = 1'b0;
    end
    check(ok, "R6 held while stalled", int'(ok), 1);
    res_ready = 1'b1;
    @(negedge osc_clk);
    check(res_valid == 1'b0, "R6 cleared after accept", int'(res_valid), 0);
    // directed corners
    dirs = '{NOM + 1, NOM - 1, NOM + 127, NOM + 128, NOM - 127, NOM - 128, NOM + 200, NOM};
    foreach (dirs[i]) run_trial(dirs[i]);
    // constrained random counts, ±200 around nominal
    for (int k = 0; k < 10; k++) begin
      rnd = NOM - 200 + int'($urandom % 401);
      run_trial(rnd);
    end
    // R1: window length follows the reference period after changes
    at0 = at;
    get_result(d, e, at0);
    get_result(d, e, at);
    check((at - at0) == rnd, "R1 window length", at - at0, rnd);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule